// File: doc/BRIEF.md
# Clock Select, Divide and Gating Unit

This unit builds the core clock and the peripheral bus clock of a chip from two sources. One is a reference clock from a crystal oscillator. The other is a fast clock from an analog PLL, which is modelled here as a clock input plus a lock status bit. The reference clock passes through a prescaler. The PLL clock is first halved and then passes through a postscaler. Both scalers divide by 1, 2, 4 or 8.

A select input picks one of the two scaled clocks. The switch-over is synchronized into both clock domains, so the output never carries a runt pulse. The bus clock runs at half the core rate. A power-mode input lets both clocks run, or holds both of them low.

Two sticky interrupt flags report clock health:
- one is raised when the PLL loses lock;
- one is raised when the reference clock stops.

A monitor that runs on the halved PLL clock watches for both conditions.

Top module: `clk_unit`

## Requirements
- R1: While reset is low, core_clk follows the reference path. With pre_div at 0 it equals ref_clk, bus_clk is held low and both flags read 0. After reset the reference path stays selected until use_pll is driven high.
- R2: With the reference path selected, the core clock period equals the ref_clk period times 2^pre_div. The pre_div values 0, 1, 2 and 3 give ratios 1, 2, 4 and 8.
- R3: With the PLL path selected, the core clock period equals 2 × 2^post_div pll_clk periods. This is a fixed halving followed by a ratio of 1, 2, 4 or 8 for post_div values 0 to 3.
- R4: use_pll = 1 makes the PLL path drive the core clock. use_pll = 0 makes the reference path drive it.
- R5: A source switch never produces a core clock high or low phase shorter than the shorter half period of the two selected scaled sources. The two source enables are never both active.
- R6: bus_clk toggles on every rising core clock edge while running, so its period is twice the core clock period.
- R7: pwr_mode encoding: 0 is run and 1 is wait, and in both the core and bus clocks toggle. 2 and 3 are stop, in which core_clk and bus_clk are held low.
- R8: A falling edge on pll_locked sets lol_irq within a few halved-PLL cycles.
- R9: loc_irq is set once ref_clk has shown no edge for 64 cycles of the halved PLL clock, and not earlier.
- R10: Both flags are sticky. Each is cleared only by holding its clear input (lol_clr, loc_clr) high for at least three halved-PLL cycles. A new set event wins over a clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock from the crystal oscillator |
| pll_clk | input | 1 | Fast clock from the PLL |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_div | input | 2 | Prescaler ratio select, ratio 2^pre_div |
| post_div | input | 2 | Postscaler ratio select, ratio 2^post_div |
| use_pll | input | 1 | 1 selects the PLL path, 0 selects the reference path |
| pwr_mode | input | 2 | 0 run, 1 wait, 2 or 3 stop |
| pll_locked | input | 1 | PLL lock indication |
| lol_clr | input | 1 | Clears the loss-of-lock flag |
| loc_clr | input | 1 | Clears the loss-of-clock flag |
| core_clk | output | 1 | Core clock |
| bus_clk | output | 1 | Peripheral bus clock, half the core rate |
| lol_irq | output | 1 | Sticky loss-of-lock flag |
| loc_irq | output | 1 | Sticky loss-of-clock flag |

## Verification
A bad divider tap or a stuck source enable shows up as a wrong core or bus clock period. This appears on the first two rising edges measured after the settle time. A fault in the handover shows up as a runt phase on core_clk during the switch itself. The bench times every phase while it toggles the select. A broken mode synchronizer or bad flag logic shows up within a few hundred nanoseconds as a clock that keeps toggling in stop, or as a flag that rises early, never rises, or fails to hold.

// File: rtl/clk_unit_pkg.sv
package clk_unit_pkg;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_WAIT  = 2'd1,
    MODE_STOP  = 2'd2,
    MODE_STOP2 = 2'd3
  } pwr_mode_e;

  // Clocks keep running in run and wait; every other code stops them.
  function automatic logic mode_keeps_clock(input logic [1:0] mode);
    return (mode == MODE_RUN) || (mode == MODE_WAIT);
  endfunction

  // Division ratio selected by a power-of-two select field.
  function automatic int unsigned pow2_ratio(input int unsigned sel);
    return 32'd1 << sel;
  endfunction

endpackage

// File: rtl/clk_pow2_div.sv
module clk_pow2_div #(
  parameter int SEL_W = 2
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             clk_out
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   taps;

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  // tap 0 is the input itself; tap k is counter bit k-1 (ratio 2^k)
  assign taps    = {cnt, clk_in};
  assign clk_out = taps[ratio_sel];
endmodule

// File: rtl/clk_glitch_mux.sv
module clk_glitch_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_side,
  input  logic pll_side,
  input  logic rst_n,
  input  logic use_pll,
  output logic mux_clk,
  output logic ref_on,
  output logic pll_on
);
  logic [SYNC_STAGES-1:0] ref_req;
  logic [SYNC_STAGES-1:0] pll_req;

  // reference side: comes up enabled out of reset
  always_ff @(posedge ref_side or negedge rst_n) begin
    if (!rst_n) ref_req <= '1;
    else        ref_req <= {ref_req[SYNC_STAGES-2:0], ~use_pll & ~pll_on};
  end

  always_ff @(negedge ref_side or negedge rst_n) begin
    if (!rst_n) ref_on <= 1'b1;
    else        ref_on <= ref_req[SYNC_STAGES-1];
  end

  // PLL side: waits until the reference side has let go
  always_ff @(posedge pll_side or negedge rst_n) begin
    if (!rst_n) pll_req <= '0;
    else        pll_req <= {pll_req[SYNC_STAGES-2:0], use_pll & ~ref_on};
  end

  always_ff @(negedge pll_side or negedge rst_n) begin
    if (!rst_n) pll_on <= 1'b0;
    else        pll_on <= pll_req[SYNC_STAGES-1];
  end

  assign mux_clk = (ref_side & ref_on) | (pll_side & pll_on);
endmodule

// File: rtl/clk_health_mon.sv
module clk_health_mon #(
  parameter int LOC_LIMIT   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic mon_clk,
  input  logic ref_clk,
  input  logic rst_n,
  input  logic pll_locked,
  input  logic lol_clr,
  input  logic loc_clr,
  output logic lol_irq,
  output logic loc_irq,
  output logic ref_dead,
  output logic lock_seen,
  output logic lol_clr_seen,
  output logic loc_clr_seen
);
  localparam int CW = $clog2(LOC_LIMIT + 1);

  logic                   ref_tog;
  logic [SYNC_STAGES:0]   ref_sync;
  logic [SYNC_STAGES:0]   lock_sync;
  logic [SYNC_STAGES-1:0] lol_clr_sync;
  logic [SYNC_STAGES-1:0] loc_clr_sync;
  logic [CW-1:0]          idle_cnt;
  logic                   dead_q;
  logic                   ref_edge;
  logic                   lock_fall;
  logic                   dead_rise;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) ref_tog <= 1'b0;
    else        ref_tog <= ~ref_tog;
  end

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_sync     <= '0;
      lock_sync    <= '0;
      lol_clr_sync <= '0;
      loc_clr_sync <= '0;
    end else begin
      ref_sync     <= {ref_sync[SYNC_STAGES-1:0], ref_tog};
      lock_sync    <= {lock_sync[SYNC_STAGES-1:0], pll_locked};
      lol_clr_sync <= {lol_clr_sync[SYNC_STAGES-2:0], lol_clr};
      loc_clr_sync <= {loc_clr_sync[SYNC_STAGES-2:0], loc_clr};
    end
  end

  assign ref_edge     = ref_sync[SYNC_STAGES] ^ ref_sync[SYNC_STAGES-1];
  assign lock_seen    = lock_sync[SYNC_STAGES-1];
  assign lock_fall    = lock_sync[SYNC_STAGES] & ~lock_seen;
  assign lol_clr_seen = lol_clr_sync[SYNC_STAGES-1];
  assign loc_clr_seen = loc_clr_sync[SYNC_STAGES-1];

  // saturating count of monitor cycles since the last reference edge
  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n)                                   idle_cnt <= '0;
    else if (ref_edge)                            idle_cnt <= '0;
    else if (idle_cnt != CW'(LOC_LIMIT))          idle_cnt <= idle_cnt + 1'b1;
  end

  assign ref_dead  = (idle_cnt == CW'(LOC_LIMIT));
  assign dead_rise = ref_dead & ~dead_q;

  always_ff @(posedge mon_clk or negedge rst_n) begin
    if (!rst_n) begin
      dead_q  <= 1'b0;
      lol_irq <= 1'b0;
      loc_irq <= 1'b0;
    end else begin
      dead_q <= ref_dead;
      if (lock_fall)         lol_irq <= 1'b1;
      else if (lol_clr_seen) lol_irq <= 1'b0;
      if (dead_rise)         loc_irq <= 1'b1;
      else if (loc_clr_seen) loc_irq <= 1'b0;
    end
  end
endmodule

// File: rtl/clk_unit.sv
module clk_unit
  import clk_unit_pkg::*;
#(
  parameter int SEL_W       = 2,
  parameter int SYNC_STAGES = 2,
  parameter int LOC_LIMIT   = 64
) (
  input  logic             ref_clk,
  input  logic             pll_clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] pre_div,
  input  logic [SEL_W-1:0] post_div,
  input  logic             use_pll,
  input  logic [1:0]       pwr_mode,
  input  logic             pll_locked,
  input  logic             lol_clr,
  input  logic             loc_clr,
  output logic             core_clk,
  output logic             bus_clk,
  output logic             lol_irq,
  output logic             loc_irq
);
  logic                   pll_half;
  logic                   ref_scaled;
  logic                   pll_scaled;
  logic                   mux_clk;
  logic                   ref_on;
  logic                   pll_on;
  logic [SYNC_STAGES-1:0] mode_sync;
  logic                   run_en;
  logic                   bus_q;
  logic                   ref_dead;
  logic                   lock_seen;
  logic                   lol_clr_seen;
  logic                   loc_clr_seen;

  // fixed halving stage in front of the postscaler
  always_ff @(posedge pll_clk or negedge rst_n) begin
    if (!rst_n) pll_half <= 1'b0;
    else        pll_half <= ~pll_half;
  end

  clk_pow2_div #(.SEL_W(SEL_W)) u_prescale (
    .clk_in(ref_clk), .rst_n(rst_n), .ratio_sel(pre_div), .clk_out(ref_scaled)
  );

  clk_pow2_div #(.SEL_W(SEL_W)) u_postscale (
    .clk_in(pll_half), .rst_n(rst_n), .ratio_sel(post_div), .clk_out(pll_scaled)
  );

  clk_glitch_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .ref_side(ref_scaled), .pll_side(pll_scaled), .rst_n(rst_n), .use_pll(use_pll),
    .mux_clk(mux_clk), .ref_on(ref_on), .pll_on(pll_on)
  );

  // power-mode gate: synchronized, enable changes only while mux_clk is low
  always_ff @(posedge mux_clk or negedge rst_n) begin
    if (!rst_n) mode_sync <= '1;
    else        mode_sync <= {mode_sync[SYNC_STAGES-2:0], mode_keeps_clock(pwr_mode)};
  end

  always_ff @(negedge mux_clk or negedge rst_n) begin
    if (!rst_n) run_en <= 1'b1;
    else        run_en <= mode_sync[SYNC_STAGES-1];
  end

  assign core_clk = mux_clk & run_en;

  // bus clock: half rate while running, parked low when stopped
  always_ff @(posedge mux_clk or negedge rst_n) begin
    if (!rst_n)      bus_q <= 1'b0;
    else if (run_en) bus_q <= ~bus_q;
    else             bus_q <= 1'b0;
  end

  assign bus_clk = bus_q;

  clk_health_mon #(.LOC_LIMIT(LOC_LIMIT), .SYNC_STAGES(SYNC_STAGES)) u_health (
    .mon_clk(pll_half), .ref_clk(ref_clk), .rst_n(rst_n), .pll_locked(pll_locked),
    .lol_clr(lol_clr), .loc_clr(loc_clr), .lol_irq(lol_irq), .loc_irq(loc_irq),
    .ref_dead(ref_dead), .lock_seen(lock_seen),
    .lol_clr_seen(lol_clr_seen), .loc_clr_seen(loc_clr_seen)
  );
endmodule

// File: rtl/clk_unit_sva.sv
module clk_unit_sva (
  input logic pll_clk,
  input logic mon_clk,
  input logic mux_clk,
  input logic rst_n,
  input logic ref_on,
  input logic pll_on,
  input logic run_en,
  input logic bus_clk,
  input logic lol_irq,
  input logic loc_irq,
  input logic ref_dead,
  input logic lock_seen,
  input logic lol_clr_seen,
  input logic loc_clr_seen
);
  assert_one_source_R5: assert property (@(posedge pll_clk) disable iff (!rst_n)
    !(ref_on && pll_on));

  assert_bus_toggles_R6: assert property (@(posedge mux_clk) disable iff (!rst_n)
    run_en |=> (bus_clk != $past(bus_clk)));

  assert_bus_parked_R7: assert property (@(posedge mux_clk) disable iff (!rst_n)
    !run_en |=> !bus_clk);

  assert_lol_from_drop_R8: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $rose(lol_irq) |-> !$past(lock_seen));

  assert_loc_from_idle_R9: assert property (@(posedge mon_clk) disable iff (!rst_n)
    $rose(loc_irq) |-> $past(ref_dead));

  assert_lol_sticky_R10: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (lol_irq && !lol_clr_seen) |=> lol_irq);

  assert_loc_sticky_R10: assert property (@(posedge mon_clk) disable iff (!rst_n)
    (loc_irq && !loc_clr_seen) |=> loc_irq);
endmodule

bind clk_unit clk_unit_sva u_sva (
  .pll_clk(pll_clk), .mon_clk(pll_half), .mux_clk(mux_clk), .rst_n(rst_n),
  .ref_on(ref_on), .pll_on(pll_on), .run_en(run_en), .bus_clk(bus_clk),
  .lol_irq(lol_irq), .loc_irq(loc_irq), .ref_dead(ref_dead), .lock_seen(lock_seen),
  .lol_clr_seen(lol_clr_seen), .loc_clr_seen(loc_clr_seen)
);

// File: tb/clk_unit_tb.sv
`timescale 1ns/1ps
module clk_unit_tb;
  localparam real REF_HALF = 5.0;   // 100 MHz reference
  localparam real PLL_HALF = 2.0;   // 250 MHz PLL
  localparam real MIN_W    = 4.0;   // shortest half period of any scaled source

  logic       ref_clk = 1'b0, pll_clk = 1'b0, rst_n = 1'b0;
  logic [1:0] pre_div = 2'd0, post_div = 2'd0, pwr_mode = 2'd0;
  logic       use_pll = 1'b0, pll_locked = 1'b1, lol_clr = 1'b0, loc_clr = 1'b0;
  logic       core_clk, bus_clk, lol_irq, loc_irq;
  bit         ref_run = 1'b1;

  int n_chk = 0, n_fail = 0;

  clk_unit u_dut (
    .ref_clk(ref_clk), .pll_clk(pll_clk), .rst_n(rst_n), .pre_div(pre_div),
    .post_div(post_div), .use_pll(use_pll), .pwr_mode(pwr_mode),
    .pll_locked(pll_locked), .lol_clr(lol_clr), .loc_clr(loc_clr),
    .core_clk(core_clk), .bus_clk(bus_clk), .lol_irq(lol_irq), .loc_irq(loc_irq)
  );

  initial forever begin #(REF_HALF); if (ref_run) ref_clk = ~ref_clk; end
  initial forever begin #(PLL_HALF); pll_clk = ~pll_clk; end

  task automatic check(input string req, input bit ok, input string what);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s", req, what);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // scoreboard of expected core clock periods
  typedef struct { string req; real period; } item_t;
  item_t exp_q[$];

  task automatic expect_period(input string req, input real period);
    item_t it;
    it.req = req;
    it.period = period;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
    #1.3;
  endtask

  initial forever begin
    realtime c0, c1, b0, b1;
    wait (exp_q.size() != 0);
    @(posedge core_clk) c0 = $realtime;
    @(posedge core_clk) c1 = $realtime;
    @(posedge bus_clk) b0 = $realtime;
    @(posedge bus_clk) b1 = $realtime;
    check(exp_q[0].req, (c1 - c0 > exp_q[0].period - 0.01) && (c1 - c0 < exp_q[0].period + 0.01),
          $sformatf("core period actual=%0.2f expected=%0.2f", c1 - c0, exp_q[0].period));
    check("R6", (b1 - b0 > 2.0 * exp_q[0].period - 0.01) && (b1 - b0 < 2.0 * exp_q[0].period + 0.01),
          $sformatf("bus period actual=%0.2f expected=%0.2f", b1 - b0, 2.0 * exp_q[0].period));
    void'(exp_q.pop_front());
  end

  // phase-width and edge counting monitors
  bit      watch = 1'b0;
  int      runts = 0;
  int      core_edges = 0;
  realtime last_edge = 0;
  always @(core_clk) begin
    if (watch && ($realtime - last_edge < MIN_W - 0.01)) runts++;
    last_edge = $realtime;
  end
  always @(posedge core_clk) core_edges++;

  task automatic check_stopped(input string req);
    int e0;
    #300;
    e0 = core_edges;
    #400;
    check(req, core_edges == e0, $sformatf("core edges in stop actual=%0d expected=%0d", core_edges - e0, 0));
    check(req, core_clk == 1'b0 && bus_clk == 1'b0,
          $sformatf("stopped levels actual=%b%b expected=00", core_clk, bus_clk));
  endtask

  initial begin
    #200_000;
    check("watchdog", 1'b0, "run did not complete actual=hung expected=done");
    report();
  end

  initial begin
    #41.3;
    // R1: during reset the core clock tracks the reference path
    check("R1", core_clk == ref_clk, $sformatf("core in reset actual=%b expected=%b", core_clk, ref_clk));
    #5;
    check("R1", core_clk == ref_clk, $sformatf("core in reset actual=%b expected=%b", core_clk, ref_clk));
    check("R1", bus_clk == 1'b0 && lol_irq == 1'b0 && loc_irq == 1'b0,
          $sformatf("bus/lol/loc in reset actual=%b%b%b expected=000", bus_clk, lol_irq, loc_irq));
    #54;
    rst_n = 1'b1;
    #300;
    expect_period("R1", 2.0 * REF_HALF);

    // R2: prescaler ratios
    for (int s = 0; s < 4; s++) begin
      pre_div = 2'(s);
      #800;
      expect_period("R2", 2.0 * REF_HALF * (1 << s));
    end

    // R3/R4: PLL path with every postscaler ratio
    pre_div = 2'd0;
    use_pll = 1'b1;
    #1000;
    for (int p = 0; p < 4; p++) begin
      post_div = 2'(p);
      #1000;
      expect_period("R3", 4.0 * PLL_HALF * (1 << p));
    end
    use_pll = 1'b0;
    #1500;
    expect_period("R4", 2.0 * REF_HALF);

    // R5: repeated switching with no runt phases
    post_div = 2'd0;
    #500;
    watch = 1'b1;
    for (int k = 0; k < 4; k++) begin
      use_pll = ~use_pll;
      #800;
      expect_period("R4", use_pll ? 4.0 * PLL_HALF : 2.0 * REF_HALF);
    end
    watch = 1'b0;
    check("R5", runts == 0, $sformatf("runt phases actual=%0d expected=%0d", runts, 0));

    // R7: power modes
    pwr_mode = 2'd1;
    #300;
    expect_period("R7", 2.0 * REF_HALF);
    pwr_mode = 2'd2;
    check_stopped("R7");
    pwr_mode = 2'd0;
    #300;
    expect_period("R7", 2.0 * REF_HALF);
    pwr_mode = 2'd3;
    check_stopped("R7");
    pwr_mode = 2'd0;
    #300;
    expect_period("R7", 2.0 * REF_HALF);

    // R8/R10: loss of lock
    check("R8", lol_irq == 1'b0, $sformatf("lol before drop actual=%b expected=0", lol_irq));
    pll_locked = 1'b0;
    #100;
    check("R8", lol_irq == 1'b1, $sformatf("lol after drop actual=%b expected=1", lol_irq));
    pll_locked = 1'b1;
    #200;
    check("R10", lol_irq == 1'b1, $sformatf("lol after relock actual=%b expected=1", lol_irq));
    lol_clr = 1'b1;
    #50;
    lol_clr = 1'b0;
    #50;
    check("R10", lol_irq == 1'b0, $sformatf("lol after clear actual=%b expected=0", lol_irq));

    // R9/R10: loss of reference clock (64 monitor cycles of 8 ns = 512 ns)
    check("R9", loc_irq == 1'b0, $sformatf("loc with ref running actual=%b expected=0", loc_irq));
    ref_run = 1'b0;
    #300;
    check("R9", loc_irq == 1'b0, $sformatf("loc too early actual=%b expected=0", loc_irq));
    #600;
    check("R9", loc_irq == 1'b1, $sformatf("loc after idle actual=%b expected=1", loc_irq));
    ref_run = 1'b1;
    #300;
    check("R10", loc_irq == 1'b1, $sformatf("loc after restart actual=%b expected=1", loc_irq));
    loc_clr = 1'b1;
    #50;
    loc_clr = 1'b0;
    #300;
    check("R10", loc_irq == 1'b0, $sformatf("loc after clear actual=%b expected=0", loc_irq));
    check("R10", lol_irq == 1'b0, $sformatf("lol untouched by loc actual=%b expected=0", lol_irq));

    report();
  end
endmodule